// File: doc/BRIEF.md
# Burst Address Generator with Restart

This block produces the address for one memory port, one address per clock. The address is a single word made of the bank number in the upper bits and the word offset inside that bank in the lower bits. On every rising clock edge the block either takes an address from outside, steps the current address by one, keeps it, or jumps back to the address most recently taken from outside. The result sits in a register and drives the memory access of the following cycle.

Every external load is also copied into a restart register, so a burst can be replayed from its start as often as needed. Stepping treats bank and offset as one number. A burst therefore runs from the last word of one bank into the first word of the next, and from the very last location back to location zero. Chip enables and byte enables never reach this block, so addressing runs on whether or not the port is selected.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `addr` becomes 0 after that edge and the block forgets any earlier load, so a restart is not yet allowed.
- R2: With `repeat_n` high and `load_n` low at an edge, `addr` equals the `ext_addr` sampled at that edge.
- R3: With `repeat_n` and `load_n` high and `cnt_en_n` low at an edge, `addr` becomes its previous value plus one.
- R4: With `repeat_n`, `load_n` and `cnt_en_n` all high at an edge, `addr` keeps its value whatever `ext_addr` holds.
- R5: `addr` is `{bank, word}`, with the bank in the upper BANK_W bits. Stepping from the top word of bank b gives word 0 of bank b+1.
- R6: Stepping from the all-ones address gives address 0.
- R7: With `repeat_n` low at an edge, after at least one load since reset, `addr` becomes the address of the most recent load before that edge.
- R8: Every edge with `load_n` low stores `ext_addr` as the restart address, even when `repeat_n` is low in the same cycle.
- R9: With `repeat_n` low at an edge and no load since reset, `addr` keeps its value.
- R10: When controls overlap, restart wins over load, and load wins over stepping. On an edge where restart and load are both asserted, `addr` takes the old restart address and the new one is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | BANK_W+WORD_W | External address, bank bits on top |
| load_n | input | 1 | Load strobe, active low |
| cnt_en_n | input | 1 | Step enable, active low |
| repeat_n | input | 1 | Restart request, active low |
| addr | output | BANK_W+WORD_W | Registered address used for the current access |

## Verification
The bench builds the block with BANK_W=2 and WORD_W=3, which gives 32 locations. At that size every address can be loaded and then stepped once. This covers each carry from offset into bank and the final wrap back to zero, and each expected value is computed as (a+1) mod 32. The small space also allows short load, step and restart sequences that check restarts before any load, restarts that coincide with loads, and holds under a changing external address.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_STEP    = 2'd1,
    OP_LOAD    = 2'd2,
    OP_RESTART = 2'd3
  } addr_op_e;
endpackage

// File: rtl/burst_ctl_decode.sv
module burst_ctl_decode
  import burst_addr_pkg::*;
(
  input  logic     load_n,
  input  logic     cnt_en_n,
  input  logic     repeat_n,
  input  logic     rpt_valid,
  output addr_op_e op
);
  // restart > load > step > hold
  always_comb begin
    if (!repeat_n) begin
      op = rpt_valid ? OP_RESTART : OP_HOLD;
    end else if (!load_n) begin
      op = OP_LOAD;
    end else if (!cnt_en_n) begin
      op = OP_STEP;
    end else begin
      op = OP_HOLD;
    end
  end
endmodule

// File: rtl/burst_rpt_reg.sv
module burst_rpt_reg #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] dout,
  output logic              valid
);
  logic [ADDR_W-1:0] store_q;
  logic              valid_q;

  // Stored address carries no reset; only the valid flag does.
  always_ff @(posedge clk) begin
    if (capture) begin
      store_q <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (capture) begin
      valid_q <= 1'b1;
    end
  end

  assign dout  = store_q;
  assign valid = valid_q;
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
  parameter int BANK_W = 2,
  parameter int WORD_W = 3
) (
  input  logic [BANK_W+WORD_W-1:0] cur,
  output logic [BANK_W+WORD_W-1:0] nxt
);
  localparam int ADDR_W = BANK_W + WORD_W;

  logic [WORD_W-1:0] word_cur;
  logic [WORD_W-1:0] word_nxt;
  logic              word_carry;

  assign word_cur   = cur[WORD_W-1:0];
  assign word_nxt   = word_cur + WORD_W'(1);
  assign word_carry = &word_cur;

  generate
    if (BANK_W == 0) begin : g_flat
      assign nxt = ADDR_W'(word_nxt);
    end else begin : g_banked
      logic [BANK_W-1:0] bank_cur;
      logic [BANK_W-1:0] bank_nxt;
      assign bank_cur = cur[ADDR_W-1:WORD_W];
      assign bank_nxt = bank_cur + BANK_W'(word_carry);
      assign nxt      = {bank_nxt, word_nxt};
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int WORD_W = 3,
  localparam int ADDR_W = BANK_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              cnt_en_n,
  input  logic              repeat_n,
  output logic [ADDR_W-1:0] addr
);
  addr_op_e          op;
  logic              rpt_valid;
  logic [ADDR_W-1:0] rpt_addr;
  logic [ADDR_W-1:0] step_addr;
  logic [ADDR_W-1:0] addr_q;

  burst_ctl_decode u_decode (
    .load_n    (load_n),
    .cnt_en_n  (cnt_en_n),
    .repeat_n  (repeat_n),
    .rpt_valid (rpt_valid),
    .op        (op)
  );

  burst_rpt_reg #(.ADDR_W(ADDR_W)) u_rpt (
    .clk     (clk),
    .rst     (rst),
    .capture (!load_n),
    .din     (ext_addr),
    .dout    (rpt_addr),
    .valid   (rpt_valid)
  );

  burst_next_addr #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_next (
    .cur (addr_q),
    .nxt (step_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      unique case (op)
        OP_RESTART: addr_q <= rpt_addr;
        OP_LOAD:    addr_q <= ext_addr;
        OP_STEP:    addr_q <= step_addr;
        default:    addr_q <= addr_q;
      endcase
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int BANK_W = 2,
  parameter int WORD_W = 3,
  localparam int ADDR_W = BANK_W + WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              load_n,
  input logic              cnt_en_n,
  input logic              repeat_n,
  input logic [ADDR_W-1:0] addr
);
  logic              seen_ld;
  logic [ADDR_W-1:0] last_ld;

  always_ff @(posedge clk) begin
    if (rst) seen_ld <= 1'b0;
    else if (!load_n) seen_ld <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!load_n) last_ld <= ext_addr;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> addr == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (repeat_n && !load_n) |=> addr == $past(ext_addr));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (repeat_n && load_n && !cnt_en_n) |=> addr == ADDR_W'($past(addr) + 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (repeat_n && load_n && cnt_en_n) |=> $stable(addr));

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (!repeat_n && seen_ld) |=> addr == $past(last_ld));

  assert_no_history_R9: assert property (@(posedge clk) disable iff (rst)
    (!repeat_n && !seen_ld) |=> $stable(addr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ext_addr (ext_addr),
  .load_n   (load_n),
  .cnt_en_n (cnt_en_n),
  .repeat_n (repeat_n),
  .addr     (addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int BANK_W = 2;
  localparam int WORD_W = 3;
  localparam int ADDR_W = BANK_W + WORD_W;
  localparam int NLOC   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] ext_addr = '0;
  logic              load_n = 1'b1;
  logic              cnt_en_n = 1'b1;
  logic              repeat_n = 1'b1;
  logic [ADDR_W-1:0] addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .load_n(load_n),
    .cnt_en_n(cnt_en_n), .repeat_n(repeat_n), .addr(addr)
  );

  task automatic drive(input logic ld, input logic ce, input logic rp, input int ea);
    load_n = ld; cnt_en_n = ce; repeat_n = rp; ext_addr = ADDR_W'(ea);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int exp);
    n_chk++;
    if (int'(addr) != exp) begin
      n_fail++;
      $display("FAIL %s: addr=%0d expected=%0d", req, addr, exp);
    end
  endtask

  function automatic int inc(input int a);
    return (a + 1) % NLOC;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    drive(1, 1, 1, 0);
    tick(); tick();
    check("R1", 0);
    rst = 1'b0;

    // R9: restart before any load keeps the address
    drive(1, 0, 1, 0); tick(); tick(); tick();
    check("R3", 3);
    drive(1, 1, 0, 0); tick();
    check("R9", 3);

    // R8/R10: restart+load with no history: address unchanged, load stored
    drive(0, 1, 0, 21); tick();
    check("R10", 3);
    drive(1, 1, 0, 0); tick();
    check("R8", 21);

    // exhaustive load then step: covers bank carry (R5) and wrap (R6)
    for (int a = 0; a < NLOC; a++) begin
      drive(0, 1, 1, a); tick();
      check("R2", a);
      drive(1, 0, 1, (a + 7) % NLOC); tick();
      if (a == NLOC - 1) check("R6", 0);
      else if ((a % (1 << WORD_W)) == (1 << WORD_W) - 1) check("R5", inc(a));
      else check("R3", inc(a));
      drive(1, 1, 1, (a + 13) % NLOC); tick();
      check("R4", inc(a));
      drive(1, 0, 1, 0); tick(); tick();
      check("R3", inc(inc(inc(a))));
      drive(1, 0, 0, 0); tick();
      check("R7", a);
    end

    // R10: load beats step
    drive(0, 0, 1, 9); tick();
    check("R10", 9);
    // R10: restart beats load; new load replaces restart address
    drive(1, 0, 1, 0); tick();
    check("R3", 10);
    drive(0, 0, 0, 30); tick();
    check("R10", 9);
    drive(1, 1, 1, 0); tick();
    check("R4", 9);
    drive(1, 0, 0, 0); tick();
    check("R8", 30);
    // repeated restarts stay at the stored address
    drive(1, 1, 0, 5); tick();
    check("R7", 30);

    // R1: reset clears history
    rst = 1'b1; drive(1, 1, 1, 0); tick();
    check("R1", 0);
    rst = 1'b0;
    drive(1, 0, 1, 0); tick();
    drive(1, 1, 0, 0); tick();
    check("R1", 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule